// File: doc/BRIEF.md
# Dual-Width Real-Time Counter with Compare Channels

This block is a free-running timekeeping counter. It advances by one on each cycle in which an upstream prescaler asserts a tick-enable. It runs in either a narrow 16-bit width or a wide 32-bit width.

In narrow width the counter returns to zero after it reaches a programmable period, and six compare channels are checked. In wide width it rolls over only after the all-ones value, and four compare channels are checked. Wide width also offers an option that restarts the count from zero once it reaches the value in compare channel 0.

Every overflow and every compare match sets a sticky flag, and software clears a flag by writing a 1 to it. Each condition can also drive a one-cycle event pulse, which is gated by its own enable bit. Software programs the block through a flat register port: a write port and an independent, combinational read port.

Top module: `rtc_dual_counter`

## Requirements
- R1: In narrow mode (CTRL bit 1 = 0), a tick taken while the low 16 bits of the count equal PERIOD (address 2, 16 bits, reset 0xFFFF) sets the count to 0 and raises overflow. A write to COUNT in narrow mode keeps only the low 16 bits of the written value.
- R2: In wide mode (CTRL bit 1 = 1), a tick taken while the count is 0xFFFFFFFF sets the count to 0 and raises overflow.
- R3: Compare channels 0 to 5 live at addresses 8 to 13. In narrow mode all six channels are active and compare 16 bits. In wide mode only channels 0 to 3 are active and compare 32 bits; channels 4 and 5 never match.
- R4: Clear-on-match is CTRL bit 2 and acts only in wide mode. When it is set, a tick taken while the count equals compare 0 sets the count to 0 with no overflow. In narrow mode the bit has no effect on counting.
- R5: FLAGS (address 3) holds overflow in bit 0 and compare channel i in bit i+1. Each bit is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A new set in the same cycle as a clear wins.
- R6: A compare match is detected only by a tick that makes the count equal the compare value. A direct write of that value to COUNT sets no flag, and counting past the value sets no further flag.
- R7: EVEN (address 4) uses the same bit layout as FLAGS and holds the event enables. ovf_evt_o and cmp_evt_o pulse for one cycle, in the cycle after the tick, only for conditions whose enable bit is set. An overflow and a match on the same tick raise both flags and both events.
- R8: After reset: CTRL reads 2 (wide mode, not running, clear-on-match off), COUNT, FLAGS, EVEN and all compares read 0, and PERIOD reads 0xFFFF.
- R9: While the run bit (CTRL bit 0) is set, writes to the mode bit, the clear-on-match bit and EVEN are ignored. The run bit itself is always writable.
- R10: The count changes only on a cycle with tick_i high and the run bit set, or on a COUNT write (address 1). A COUNT write takes effect at the next clock edge and overrides a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable strobe from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| ovf_evt_o | output | 1 | Overflow event pulse |
| cmp_evt_o | output | 6 | Compare event pulses, bit i for channel i |

## Verification
The bench aims at the mode-dependent edges. The narrow wrap must occur at the period rather than at 0xFFFF, or the count would run on past it. The wide wrap must raise overflow. Channels 4 and 5 must stay silent in wide mode; a design that ignored the mode would set their flags. Clear-on-match must restart the count without flagging overflow.

A single wrap that also matches several compares checks that all flags are set while only the enabled events fire. Further cases cover a COUNT write that coincides with a tick, configuration writes attempted while running, and a compare value reached by a write rather than by counting. A design that let the tick win, accepted locked writes, or flagged a written value would fail these checks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CNT_W      = 32;
    localparam int NARROW_W   = 16;
    localparam int ADDR_W     = 4;
    localparam int CMP_NARROW = 6;
    localparam int CMP_WIDE   = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_PERIOD = 4'd2;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd3;
    localparam logic [ADDR_W-1:0] A_EVEN   = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMP0   = 4'd8;

    // control bit positions
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_WIDE = 1;
    localparam int CTRL_CLR  = 2;

endpackage

// File: rtl/rtc_count_step.sv
// Next-count computation for one tick: wrap at period (narrow),
// wrap at all-ones or restart on compare 0 (wide).
module rtc_count_step #(
    parameter int W  = 32,
    parameter int NW = 16
) (
    input  logic [W-1:0]  cnt_i,
    input  logic [NW-1:0] period_i,
    input  logic          wide_i,
    input  logic          clr_en_i,
    input  logic [W-1:0]  cmp0_i,
    output logic [W-1:0]  nxt_o,
    output logic          wrap_o
);

    localparam logic [NW-1:0] NARROW_MAX = '1;

    logic [NW-1:0] low;

    always_comb begin
        low    = cnt_i[NW-1:0];
        nxt_o  = cnt_i + W'(1);
        wrap_o = 1'b0;
        if (wide_i) begin
            if (clr_en_i && (cnt_i == cmp0_i)) begin
                nxt_o = '0;
            end else if (cnt_i == '1) begin
                nxt_o  = '0;
                wrap_o = 1'b1;
            end
        end else begin
            if ((low == period_i) || (low == NARROW_MAX)) begin
                nxt_o  = '0;
                wrap_o = 1'b1;
            end else begin
                nxt_o = W'(low + NW'(1));
            end
        end
    end

endmodule

// File: rtl/rtc_cmp_bank.sv
// Compare registers and per-channel match detection on the next count.
module rtc_cmp_bank #(
    parameter int W     = 32,
    parameter int NW    = 16,
    parameter int N     = 6,
    parameter int NWIDE = 4,
    parameter int AW    = 4,
    parameter int BASE  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic          step_i,
    input  logic          wide_i,
    input  logic [W-1:0]  nxt_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_val_o,
    output logic [W-1:0]  cmp0_o,
    output logic [N-1:0]  hit_o
);

    logic [W-1:0] cmp_d [N];
    logic [W-1:0] cmp_q [N];

    for (genvar i = 0; i < N; i++) begin : g_ch
        localparam logic [AW-1:0] MY_ADDR   = AW'(BASE + i);
        localparam bit            WIDE_LIVE = (i < NWIDE);

        logic active;
        logic equal;

        always_comb begin
            cmp_d[i] = cmp_q[i];
            if (wr_en_i && (wr_addr_i == MY_ADDR)) begin
                cmp_d[i] = wr_data_i;
            end
            active   = WIDE_LIVE ? 1'b1 : !wide_i;
            equal    = wide_i ? (nxt_i == cmp_q[i])
                              : (nxt_i[NW-1:0] == cmp_q[i][NW-1:0]);
            hit_o[i] = step_i && active && equal;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cmp_q[i] <= '0;
            else        cmp_q[i] <= cmp_d[i];
        end
    end

    always_comb begin
        rd_val_o = '0;
        for (int k = 0; k < N; k++) begin
            if (rd_addr_i == AW'(BASE + k)) rd_val_o = cmp_q[k];
        end
    end

    assign cmp0_o = cmp_q[0];

endmodule

// File: rtl/rtc_dual_counter.sv
module rtc_dual_counter
    import rtc_pkg::*;
#(
    parameter int C_W  = CNT_W,
    parameter int N_W  = NARROW_W,
    parameter int N_CH = CMP_NARROW,
    parameter int N_CW = CMP_WIDE,
    parameter int AW   = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [C_W-1:0]  wr_data_i,
    input  logic [AW-1:0]   rd_addr_i,
    output logic [C_W-1:0]  rd_data_o,
    output logic            ovf_evt_o,
    output logic [N_CH-1:0] cmp_evt_o
);

    localparam int NF = N_CH + 1;

    typedef struct packed {
        logic [C_W-1:0] count;
        logic [N_W-1:0] period;
        logic           run;
        logic           wide;
        logic           clr;
        logic [NF-1:0]  flags;
        logic [NF-1:0]  evt_en;
        logic [NF-1:0]  evt;
    } state_t;

    state_t s_d, s_q;

    logic            cnt_wr;
    logic            s_step;
    logic [C_W-1:0]  nxt;
    logic            wrap;
    logic [C_W-1:0]  cmp0;
    logic [C_W-1:0]  cmp_rd;
    logic [N_CH-1:0] cmp_hit;
    logic [NF-1:0]   ev;
    logic [NF-1:0]   clr_mask;

    assign cnt_wr = wr_en_i && (wr_addr_i == A_COUNT);
    assign s_step = tick_i && s_q.run && !cnt_wr;

    rtc_count_step #(.W(C_W), .NW(N_W)) u_step (
        .cnt_i    (s_q.count),
        .period_i (s_q.period),
        .wide_i   (s_q.wide),
        .clr_en_i (s_q.clr),
        .cmp0_i   (cmp0),
        .nxt_o    (nxt),
        .wrap_o   (wrap)
    );

    rtc_cmp_bank #(
        .W(C_W), .NW(N_W), .N(N_CH), .NWIDE(N_CW), .AW(AW), .BASE(int'(A_CMP0))
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .step_i    (s_step),
        .wide_i    (s_q.wide),
        .nxt_i     (nxt),
        .rd_addr_i (rd_addr_i),
        .rd_val_o  (cmp_rd),
        .cmp0_o    (cmp0),
        .hit_o     (cmp_hit)
    );

    always_comb begin
        s_d      = s_q;
        ev       = {cmp_hit, wrap && s_step};
        clr_mask = '0;
        if (s_step) s_d.count = nxt;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_CTRL: begin
                    s_d.run = wr_data_i[CTRL_RUN];
                    if (!s_q.run) begin
                        s_d.wide = wr_data_i[CTRL_WIDE];
                        s_d.clr  = wr_data_i[CTRL_CLR];
                    end
                end
                A_COUNT:  s_d.count  = s_q.wide ? wr_data_i : C_W'(wr_data_i[N_W-1:0]);
                A_PERIOD: s_d.period = wr_data_i[N_W-1:0];
                A_FLAGS:  clr_mask   = wr_data_i[NF-1:0];
                A_EVEN:   if (!s_q.run) s_d.evt_en = wr_data_i[NF-1:0];
                default: ;
            endcase
        end
        s_d.flags = (s_q.flags & ~clr_mask) | ev;
        s_d.evt   = ev & s_q.evt_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.wide   <= 1'b1;
            s_q.period <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (rd_addr_i)
            A_CTRL:   rd_data_o = C_W'({s_q.clr, s_q.wide, s_q.run});
            A_COUNT:  rd_data_o = s_q.count;
            A_PERIOD: rd_data_o = C_W'(s_q.period);
            A_FLAGS:  rd_data_o = C_W'(s_q.flags);
            A_EVEN:   rd_data_o = C_W'(s_q.evt_en);
            default:  rd_data_o = cmp_rd;
        endcase
    end

    assign ovf_evt_o = s_q.evt[0];
    assign cmp_evt_o = s_q.evt[NF-1:1];

    assert_narrow_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_step && !s_q.wide && s_q.count[N_W-1:0] == s_q.period)
        |=> (s_q.count == '0 && s_q.flags[0]));

    assert_wide_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_step && s_q.wide && s_q.count == '1 && !(s_q.clr && s_q.count == cmp0))
        |=> (s_q.count == '0 && s_q.flags[0]));

    assert_upper_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wide |-> (cmp_hit[N_CH-1:N_CW] == '0));

    assert_clear_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_step && s_q.wide && s_q.clr && s_q.count == cmp0)
        |=> (s_q.count == '0 && !ovf_evt_o));

    assert_evt_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_q.evt) |-> (((s_q.evt & ~s_q.evt_en) == '0) && ((s_q.evt & ~s_q.flags) == '0)));

    assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && $past(s_q.run))
        |-> ($stable(s_q.wide) && $stable(s_q.clr) && $stable(s_q.evt_en)));

    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_step && !cnt_wr) |=> $stable(s_q.count));

endmodule

// File: tb/rtc_dual_counter_bench.sv
module rtc_dual_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;
    logic        ovf_evt_o;
    logic [5:0]  cmp_evt_o;

    always #5 clk = ~clk;

    rtc_dual_counter u_rtc_dual_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .ovf_evt_o(ovf_evt_o), .cmp_evt_o(cmp_evt_o)
    );

    typedef struct {
        bit          is_evt;
        logic [3:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // monitor: pops expectations and compares, away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                rd_addr_i = it.addr;
                #1;
                act = it.is_evt ? 32'({cmp_evt_o, ovf_evt_o}) : rd_data_o;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", it.req, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] v, input string r);
        item_t it;
        it.is_evt = 0; it.addr = a; it.exp = v; it.req = r;
        q.push_back(it);
    endtask

    task automatic expect_ev(input logic [31:0] v, input string r);
        item_t it;
        it.is_evt = 1; it.addr = 4'd0; it.exp = v; it.req = r;
        q.push_back(it);
    endtask

    task automatic idle(input int n, input logic t);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en_i = 1'b0;
            tick_i  = t;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_addr_i = a;
        wr_data_i = d;
        tick_i    = t;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1, 0);
        // reset values
        expect_rd(4'd0, 32'h2, "R8 ctrl");
        expect_rd(4'd1, 32'h0, "R8 count");
        expect_rd(4'd2, 32'hFFFF, "R8 period");
        idle(1, 0);
        expect_rd(4'd3, 32'h0, "R8 flags");
        expect_rd(4'd4, 32'h0, "R8 even");
        expect_rd(4'd8, 32'h0, "R8 cmp0");
        // R10: no counting while stopped
        idle(3, 1);
        idle(1, 0);
        expect_rd(4'd1, 32'h0, "R10 stopped");
        wr(4'd0, 32'h3, 0);
        idle(5, 1);
        idle(1, 0);
        expect_rd(4'd1, 32'd5, "R10 five ticks");
        wr(4'd1, 32'd100, 1);
        idle(1, 0);
        expect_rd(4'd1, 32'd100, "R10 write beats tick");
        // R9: locked config while running
        wr(4'd0, 32'h5, 0);
        wr(4'd4, 32'h7F, 0);
        idle(1, 0);
        expect_rd(4'd0, 32'h3, "R9 ctrl locked");
        expect_rd(4'd4, 32'h0, "R9 even locked");
        wr(4'd0, 32'h0, 0);
        idle(1, 0);
        expect_rd(4'd0, 32'h2, "R9 run only");
        // R2 wide wrap, all compares zero: ch0..3 match, only ovf event enabled
        wr(4'd4, 32'h01, 0);
        wr(4'd1, 32'hFFFF_FFFE, 0);
        wr(4'd0, 32'h3, 0);
        idle(2, 1);
        idle(1, 0);
        expect_rd(4'd1, 32'h0, "R2 wrap count");
        expect_rd(4'd3, 32'h1F, "R3 wide flags");
        expect_ev(32'h01, "R7 gated event");
        idle(1, 0);
        expect_ev(32'h00, "R7 one cycle");
        wr(4'd3, 32'h0, 0);
        idle(1, 0);
        expect_rd(4'd3, 32'h1F, "R5 write zero keeps");
        wr(4'd3, 32'h1, 0);
        idle(1, 0);
        expect_rd(4'd3, 32'h1E, "R5 clear one");
        wr(4'd3, 32'h7F, 0);
        // wide compares: ch4/ch5 inactive
        wr(4'd0, 32'h2, 0);
        wr(4'd1, 32'h0, 0);
        wr(4'd9, 32'd3, 0);
        wr(4'd10, 32'h100, 0);
        wr(4'd11, 32'h100, 0);
        wr(4'd12, 32'd3, 0);
        wr(4'd13, 32'd2, 0);
        wr(4'd4, 32'h7F, 0);
        wr(4'd0, 32'h3, 0);
        idle(3, 1);
        idle(1, 0);
        expect_ev(32'h04, "R3 ch1 event only");
        expect_rd(4'd3, 32'h04, "R3 ch1 flag only");
        wr(4'd3, 32'h04, 0);
        idle(2, 1);
        idle(1, 0);
        expect_rd(4'd1, 32'd5, "R6 count past");
        expect_rd(4'd3, 32'h0, "R6 no repeat");
        wr(4'd1, 32'd3, 0);
        idle(1, 0);
        expect_rd(4'd3, 32'h0, "R6 written value no flag");
        // R1 narrow wrap at period
        wr(4'd0, 32'h0, 0);
        wr(4'd0, 32'h0, 0);
        wr(4'd2, 32'd4, 0);
        wr(4'd1, 32'h12345, 0);
        idle(1, 0);
        expect_rd(4'd1, 32'h2345, "R1 narrow write");
        wr(4'd1, 32'd3, 0);
        wr(4'd12, 32'd4, 0);
        wr(4'd13, 32'd0, 0);
        wr(4'd3, 32'h7F, 0);
        wr(4'd0, 32'h1, 0);
        idle(1, 1);
        idle(1, 0);
        expect_rd(4'd1, 32'd4, "R3 narrow ch4");
        expect_ev(32'h20, "R3 ch4 event");
        idle(1, 1);
        idle(1, 0);
        expect_rd(4'd1, 32'd0, "R1 period wrap");
        expect_ev(32'h43, "R7 ovf with matches");
        expect_rd(4'd3, 32'h63, "R5 flags accumulate");
        // R4 clear on match (wide)
        wr(4'd0, 32'h0, 0);
        wr(4'd0, 32'h6, 0);
        wr(4'd8, 32'd2, 0);
        wr(4'd1, 32'd0, 0);
        wr(4'd3, 32'h7F, 0);
        wr(4'd0, 32'h7, 0);
        idle(3, 1);
        idle(1, 0);
        expect_rd(4'd1, 32'd0, "R4 restart");
        expect_rd(4'd3, 32'h02, "R4 no overflow");
        // R4 no effect in narrow mode
        wr(4'd0, 32'h0, 0);
        wr(4'd0, 32'h4, 0);
        wr(4'd1, 32'd1, 0);
        wr(4'd0, 32'h5, 0);
        idle(2, 1);
        idle(1, 0);
        expect_rd(4'd1, 32'd3, "R4 ignored narrow");
        idle(2, 0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
        end
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule